// File: doc/BRIEF.md
# Delayed Special Cycle Sequencer

This block carries one configuration write, already chosen by upstream decode for conversion into a special cycle, from the initiating bus to the target bus as a delayed transaction. The first attempt from the requester is retried. At the same time the block captures the address, command and the single data word of that attempt. It then asks for the target bus, drives a special cycle that carries the captured address and data unchanged, and waits until the target bus ends that cycle. The target bus normally ends a special cycle with a master abort, because no device claims one.

A master abort on the target side counts as a successful completion and is never reported back as a fault. After completion, the requester returns with the same transaction and the block answers with a ready response, which frees the entry. If the requester asks for a burst, the ready comes together with a disconnect, so only one word moves. If the requester never returns, a parameterised timer frees the finished entry. Only one transaction is held at a time.

Top module: `spc_delay_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, ini_retry, ini_ready, ini_disc, tgt_req and tgt_start are all low and no entry is held.
- R2: When no entry is held, an attempt (ini_req high for one cycle) is answered with ini_retry high in the following cycle. Its address, command and data are captured.
- R3: tgt_req goes high in the cycle after the captured attempt and stays high until a cycle in which tgt_gnt is sampled high.
- R4: In the cycle after the grant, tgt_start is high for exactly one cycle and tgt_req is low. While the entry is held, tgt_addr and tgt_data equal the captured values and tgt_cmd is the special cycle code 4'b0001.
- R5: Any attempt made while the entry waits for the grant, is being issued or waits for the target to end the cycle is retried, even one that matches the entry.
- R6: A cycle with tgt_mabort high or tgt_done high ends the target-side wait and marks the entry complete. A master abort leads to a ready response, not to any error.
- R7: When the entry is complete, an attempt whose address, command (configuration write 4'b1011) and data all equal the captured values gets ini_ready high and ini_retry low in the following cycle. The entry is then freed, and the next attempt starts a new transaction.
- R8: When the entry is complete, an attempt that differs in address, command or data is retried, and the entry is kept.
- R9: ini_disc is high together with ini_ready when the accepted attempt had ini_multi high. It is low when ini_multi was low.
- R10: A complete entry is freed after DISCARD_CYCLES clocks without a matching attempt. A matching attempt in the last of those cycles is still accepted. One cycle later, the same attempt starts a new transaction instead.
- R11: A reset asserted while a transaction is pending drops it. The next attempt is treated as a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ini_req | input | 1 | One-cycle attempt strobe from the initiating bus |
| ini_addr | input | AW | Address of the attempt |
| ini_cmd | input | 4 | Bus command of the attempt |
| ini_data | input | DW | Data word of the attempt |
| ini_multi | input | 1 | Attempt requests more than one data transfer |
| ini_retry | output | 1 | Retry response, one cycle after the attempt |
| ini_ready | output | 1 | Ready response, one cycle after the attempt |
| ini_disc | output | 1 | Disconnect given with the ready response |
| tgt_req | output | 1 | Request for the target bus |
| tgt_gnt | input | 1 | Target bus granted |
| tgt_start | output | 1 | One-cycle start of the special cycle |
| tgt_addr | output | AW | Forwarded address |
| tgt_cmd | output | 4 | Forwarded command, always the special cycle code |
| tgt_data | output | DW | Forwarded message word |
| tgt_done | input | 1 | Target-side cycle ended normally |
| tgt_mabort | input | 1 | Target-side cycle ended by master abort |

## Verification
A state register stuck in the wait phase shows up within one attempt. The matching retry after the master abort returns ini_retry where ini_ready was due, in the cycle right after that attempt. A corrupted capture or a faulty compare is exposed when tgt_addr and tgt_data differ from the driven attempt in the cycle tgt_req rises. It also shows when a mismatched attempt in the complete state is wrongly answered with ready. An off-by-one in the discard counter appears only at the expiry boundary, so attempts are placed exactly in the last held cycle and in the cycle after it.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int unsigned CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_CFG_WRITE = 4'b1011;
    localparam logic [CMD_W-1:0] CMD_SPECIAL   = 4'b0001;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_QUEUED     = 3'd1,
        ST_ISSUE      = 3'd2,
        ST_WAIT_ABORT = 3'd3,
        ST_COMPLETE   = 3'd4
    } spc_state_e;

    typedef struct packed {
        logic retry;
        logic ready;
        logic disc;
    } spc_resp_t;

endpackage

// File: rtl/spc_entry_match.sv
module spc_entry_match #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic [AW-1:0]            ent_addr,
    input  logic [spc_pkg::CMD_W-1:0] ent_cmd,
    input  logic [DW-1:0]            ent_data,
    input  logic [AW-1:0]            cur_addr,
    input  logic [spc_pkg::CMD_W-1:0] cur_cmd,
    input  logic [DW-1:0]            cur_data,
    output logic                     hit
);

    logic addr_eq;
    logic cmd_eq;
    logic data_eq;

    always_comb begin
        addr_eq = (ent_addr == cur_addr);
        cmd_eq  = (ent_cmd  == cur_cmd);
        data_eq = (ent_data == cur_data);
        hit     = addr_eq && cmd_eq && data_eq;
    end

endmodule

// File: rtl/spc_discard_timer.sv
module spc_discard_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LAST) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        expire = run && (r_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/spc_delay_ctrl.sv
module spc_delay_ctrl
    import spc_pkg::*;
#(
    parameter int unsigned AW             = 32,
    parameter int unsigned DW             = 32,
    parameter int unsigned DISCARD_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ini_req,
    input  logic [AW-1:0]     ini_addr,
    input  logic [CMD_W-1:0]  ini_cmd,
    input  logic [DW-1:0]     ini_data,
    input  logic              ini_multi,
    output logic              ini_retry,
    output logic              ini_ready,
    output logic              ini_disc,
    output logic              tgt_req,
    input  logic              tgt_gnt,
    output logic              tgt_start,
    output logic [AW-1:0]     tgt_addr,
    output logic [CMD_W-1:0]  tgt_cmd,
    output logic [DW-1:0]     tgt_data,
    input  logic              tgt_done,
    input  logic              tgt_mabort
);

    typedef struct packed {
        spc_state_e        st;
        logic [AW-1:0]     addr;
        logic [CMD_W-1:0]  cmd;
        logic [DW-1:0]     data;
        spc_resp_t         resp;
    } ctl_t;

    ctl_t c_d, c_q;

    logic hit;
    logic expire;
    logic in_complete;
    logic tgt_end;

    assign in_complete = (c_q.st == ST_COMPLETE);
    assign tgt_end     = tgt_done || tgt_mabort;

    spc_entry_match #(
        .AW (AW),
        .DW (DW)
    ) i_match (
        .ent_addr (c_q.addr),
        .ent_cmd  (c_q.cmd),
        .ent_data (c_q.data),
        .cur_addr (ini_addr),
        .cur_cmd  (ini_cmd),
        .cur_data (ini_data),
        .hit      (hit)
    );

    spc_discard_timer #(
        .LIMIT (DISCARD_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (in_complete),
        .expire (expire)
    );

    always_comb begin
        c_d      = c_q;
        c_d.resp = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (ini_req) begin
                    c_d.addr       = ini_addr;
                    c_d.cmd        = ini_cmd;
                    c_d.data       = ini_data;
                    c_d.resp.retry = 1'b1;
                    c_d.st         = ST_QUEUED;
                end
            end
            ST_QUEUED: begin
                c_d.resp.retry = ini_req;
                if (tgt_gnt) begin
                    c_d.st = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                c_d.resp.retry = ini_req;
                c_d.st         = ST_WAIT_ABORT;
            end
            ST_WAIT_ABORT: begin
                c_d.resp.retry = ini_req;
                if (tgt_end) begin
                    c_d.st = ST_COMPLETE;
                end
            end
            ST_COMPLETE: begin
                if (ini_req && hit) begin
                    c_d.resp.ready = 1'b1;
                    c_d.resp.disc  = ini_multi;
                    c_d.st         = ST_IDLE;
                    c_d.addr       = '0;
                    c_d.cmd        = '0;
                    c_d.data       = '0;
                end else begin
                    c_d.resp.retry = ini_req;
                    if (expire) begin
                        c_d.st   = ST_IDLE;
                        c_d.addr = '0;
                        c_d.cmd  = '0;
                        c_d.data = '0;
                    end
                end
            end
            default: begin
                c_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign ini_retry = c_q.resp.retry;
    assign ini_ready = c_q.resp.ready;
    assign ini_disc  = c_q.resp.disc;
    assign tgt_req   = (c_q.st == ST_QUEUED);
    assign tgt_start = (c_q.st == ST_ISSUE);
    assign tgt_addr  = c_q.addr;
    assign tgt_data  = c_q.data;
    assign tgt_cmd   = CMD_SPECIAL;

endmodule

// File: rtl/spc_delay_ctrl_chk.sv
module spc_delay_ctrl_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ini_req,
    input logic          ini_retry,
    input logic          ini_ready,
    input logic          ini_disc,
    input logic          tgt_req,
    input logic          tgt_gnt,
    input logic          tgt_start,
    input logic [AW-1:0] tgt_addr,
    input logic [DW-1:0] tgt_data
);

    a_r7_one_response: assert property (@(posedge clk) disable iff (rst)
        !(ini_retry && ini_ready));

    a_r2_retry_needs_attempt: assert property (@(posedge clk) disable iff (rst)
        ini_retry |-> $past(ini_req));

    a_r7_ready_needs_attempt: assert property (@(posedge clk) disable iff (rst)
        ini_ready |-> $past(ini_req));

    a_r9_disc_with_ready: assert property (@(posedge clk) disable iff (rst)
        ini_disc |-> ini_ready);

    a_r3_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (tgt_req && !tgt_gnt) |=> tgt_req);

    a_r4_start_after_grant: assert property (@(posedge clk) disable iff (rst)
        tgt_start |-> $past(tgt_req && tgt_gnt));

    a_r4_single_start: assert property (@(posedge clk) disable iff (rst)
        tgt_start |=> !tgt_start);

    a_r4_fields_stable: assert property (@(posedge clk) disable iff (rst)
        tgt_req |=> ($stable(tgt_addr) && $stable(tgt_data)));

endmodule

bind spc_delay_ctrl spc_delay_ctrl_chk #(
    .AW (AW),
    .DW (DW)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ini_req   (ini_req),
    .ini_retry (ini_retry),
    .ini_ready (ini_ready),
    .ini_disc  (ini_disc),
    .tgt_req   (tgt_req),
    .tgt_gnt   (tgt_gnt),
    .tgt_start (tgt_start),
    .tgt_addr  (tgt_addr),
    .tgt_data  (tgt_data)
);

// File: tb/test_spc_delay_ctrl.sv
module test_spc_delay_ctrl;

    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned D  = 6;
    localparam logic [3:0] CFGW = 4'b1011;
    localparam logic [3:0] SPEC = 4'b0001;

    localparam int NV = 4;
    localparam logic [64:0] VEC [0:NV-1] = '{
        {32'h0001_FF04, 32'h0000_0001, 1'b0},
        {32'h00AB_FF04, 32'hDEAD_BEEF, 1'b1},
        {32'hFFFF_FFFD, 32'h0000_0000, 1'b0},
        {32'h0012_F800, 32'hFFFF_FFFF, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ini_req = 1'b0;
    logic [AW-1:0] ini_addr = '0;
    logic [3:0] ini_cmd = '0;
    logic [DW-1:0] ini_data = '0;
    logic ini_multi = 1'b0;
    logic ini_retry, ini_ready, ini_disc;
    logic tgt_req, tgt_start;
    logic tgt_gnt = 1'b0;
    logic tgt_done = 1'b0;
    logic tgt_mabort = 1'b0;
    logic [AW-1:0] tgt_addr;
    logic [3:0] tgt_cmd;
    logic [DW-1:0] tgt_data;

    int n_chk = 0;
    int n_err = 0;
    logic s_retry, s_ready, s_disc;

    always #5 clk = ~clk;

    spc_delay_ctrl #(
        .AW (AW),
        .DW (DW),
        .DISCARD_CYCLES (D)
    ) i_spc_delay_ctrl (
        .clk (clk), .rst (rst),
        .ini_req (ini_req), .ini_addr (ini_addr), .ini_cmd (ini_cmd),
        .ini_data (ini_data), .ini_multi (ini_multi),
        .ini_retry (ini_retry), .ini_ready (ini_ready), .ini_disc (ini_disc),
        .tgt_req (tgt_req), .tgt_gnt (tgt_gnt), .tgt_start (tgt_start),
        .tgt_addr (tgt_addr), .tgt_cmd (tgt_cmd), .tgt_data (tgt_data),
        .tgt_done (tgt_done), .tgt_mabort (tgt_mabort)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive one attempt, sample the response one cycle later.
    task automatic attempt(input logic [AW-1:0] a, input logic [3:0] c,
                           input logic [DW-1:0] d, input logic m);
        ini_req = 1'b1; ini_addr = a; ini_cmd = c; ini_data = d; ini_multi = m;
        @(negedge clk);
        ini_req = 1'b0;
        s_retry = ini_retry; s_ready = ini_ready; s_disc = ini_disc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // From idle: capture, grant, issue, end with done or master abort.
    task automatic to_complete(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic use_abort);
        attempt(a, CFGW, d, 1'b0);
        tgt_gnt = 1'b1; @(negedge clk); tgt_gnt = 1'b0;
        @(negedge clk);
        if (use_abort) tgt_mabort = 1'b1; else tgt_done = 1'b1;
        @(negedge clk);
        tgt_mabort = 1'b0; tgt_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1 retry in reset", ini_retry, 0);
        chk("R1 tgt_req in reset", tgt_req, 0);
        chk("R1 tgt_start in reset", tgt_start, 0);
        rst = 1'b0;
        idle(1);
        chk("R1 ready after reset", {ini_ready, ini_disc}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic m;
            a = VEC[v][64:33]; d = VEC[v][32:1]; m = VEC[v][0];
            attempt(a, CFGW, d, m);
            chk("R2 first attempt retried", {s_retry, s_ready}, 2'b10);
            chk("R3 tgt_req raised", tgt_req, 1);
            chk("R4 R7 tgt_addr captured", tgt_addr, a);
            chk("R4 tgt_data captured", tgt_data, d);
            chk("R4 tgt_cmd special", tgt_cmd, SPEC);
            attempt(a, CFGW, d, m);
            chk("R5 queued attempt retried", {s_retry, s_ready}, 2'b10);
            chk("R3 tgt_req held", tgt_req, 1);
            tgt_gnt = 1'b1; @(negedge clk); tgt_gnt = 1'b0;
            chk("R4 start after grant", {tgt_start, tgt_req}, 2'b10);
            @(negedge clk);
            chk("R4 start one cycle", tgt_start, 0);
            attempt(a, CFGW, d, m);
            chk("R5 waiting attempt retried", {s_retry, s_ready}, 2'b10);
            tgt_mabort = 1'b1; @(negedge clk); tgt_mabort = 1'b0;
            attempt(a, CFGW, d ^ 32'h1, m);
            chk("R8 data mismatch retried", {s_retry, s_ready}, 2'b10);
            attempt(a ^ 32'h100, CFGW, d, m);
            chk("R8 addr mismatch retried", {s_retry, s_ready}, 2'b10);
            attempt(a, 4'b1010, d, m);
            chk("R8 cmd mismatch retried", {s_retry, s_ready}, 2'b10);
            attempt(a, CFGW, d, m);
            chk("R6 R7 ready after master abort", {s_retry, s_ready}, 2'b01);
            chk("R9 disconnect follows multi", s_disc, m);
        end

        // R6: normal end also completes
        to_complete(32'h0000_0101, 32'h55, 1'b0);
        attempt(32'h0000_0101, CFGW, 32'h55, 1'b0);
        chk("R6 ready after done", {s_retry, s_ready, s_disc}, 3'b010);

        // R10 boundary: attempt sampled in last held cycle
        to_complete(32'h0000_0202, 32'h66, 1'b1);
        idle(D - 1);
        attempt(32'h0000_0202, CFGW, 32'h66, 1'b1);
        chk("R10 last cycle accepted", {s_retry, s_ready, s_disc}, 3'b011);

        // R10: one cycle later the entry is gone
        to_complete(32'h0000_0303, 32'h77, 1'b1);
        idle(D);
        attempt(32'h0000_0303, CFGW, 32'h77, 1'b0);
        chk("R10 discarded entry retried", {s_retry, s_ready}, 2'b10);
        chk("R10 new transaction queued", tgt_req, 1);

        // R11: reset drops pending entry
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R11 tgt_req cleared", tgt_req, 0);
        attempt(32'h0000_0404, CFGW, 32'h88, 1'b0);
        chk("R11 new attempt retried", {s_retry, s_ready}, 2'b10);
        chk("R11 new address captured", tgt_addr, 32'h0000_0404);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule